// File: doc/BRIEF.md
# Synchronizing single-slot handoff register

This block is a one-entry blocking channel between one producer and one consumer that run in parallel. It holds a single data word and a full/empty flag. The producer raises a write request with its data and holds both until a write-complete pulse appears. The consumer raises a read request and holds it until a read-complete pulse appears. In the pulse cycle it takes the word from the data output.

Each request completes only when the flag allows it. A write needs the slot empty, and a read needs it full. A read consumes the word, so a second read waits for a new write. When both requests arrive together, only the one the current state permits completes. The other waits, and finishes on a later cycle after the state has flipped. A blocked output flags every cycle in which some request is held but cannot complete.

Top module: `sync_slot_reg`

## Requirements
- R1: During and right after a synchronous active-high reset, the slot is empty (`full` = 0), `rd_data` is zero, and both `wr_done` and `rd_done` are 0.
- R2: A write request seen at a clock edge while the slot is empty stores `wr_data`, sets `full` to 1, and gives `wr_done` = 1 in the cycle after that edge.
- R3: A write request while the slot is full does not complete: `wr_done` stays 0 and the stored word stays unchanged, for as long as the slot stays full.
- R4: A read request seen at an edge while the slot is full clears `full` and gives `rd_done` = 1 in the next cycle. In that cycle `rd_data` shows the word that was stored.
- R5: A read request while the slot is empty does not complete, and `rd_done` stays 0 until a write has filled the slot.
- R6: After a successful read, a further read without an intervening write blocks.
- R7: With both requests held while the slot is full, the read completes first and the write does not. The held write then completes at the following edge.
- R8: With both requests held while the slot is empty, the write completes first and the read does not. The held read then completes at the following edge and returns the new word.
- R9: `wr_done` and `rd_done` are single-cycle pulses and are never high in the same cycle.
- R10: `wr_data` is sampled only at the edge where a write completes. Changes to it while a write is stalled do not reach `rd_data`.
- R11: `blocked` is 1 exactly when (`rd_req` and slot empty) or (`wr_req` and slot full), and 0 otherwise.
- R12: Words written and read in alternation come out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_req | input | 1 | Write request, held until `wr_done` |
| wr_done | output | 1 | One-cycle write-complete pulse |
| rd_req | input | 1 | Read request, held until `rd_done` |
| rd_done | output | 1 | One-cycle read-complete pulse |
| rd_data | output | DATA_W | Stored word; valid with `rd_done` and while full |
| full | output | 1 | Slot state: 1 full, 0 empty |
| blocked | output | 1 | A held request cannot complete this cycle |

## Verification
The hardest cases to reach are the ones where both requests are held at the same edge. The state then decides the winner, and the loser must finish exactly one edge later without a duplicate completion. To reach them, the bench first puts the slot into a known state with a single write or read. It then raises both requests on the same falling edge. After that it drops only the winner's request and checks both pulses cycle by cycle. The stall cases are also driven while `wr_data` changes on every cycle, so that any early capture of the data would show up at `rd_data`.

// File: rtl/sync_slot_pkg.sv
package sync_slot_pkg;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_WR   = 0;
  localparam int unsigned SIDE_RD   = 1;

endpackage

// File: rtl/sync_slot_ctrl.sv
module sync_slot_ctrl
  import sync_slot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_go,
  output logic rd_go,
  output logic is_full,
  output logic blocked
);

  slot_state_e state_q;
  slot_state_e state_d;

  // Only the operation the present state allows may proceed.
  always_comb begin
    wr_go   = 1'b0;
    rd_go   = 1'b0;
    state_d = state_q;
    if (state_q == SLOT_EMPTY) begin
      if (wr_req) begin
        wr_go   = 1'b1;
        state_d = SLOT_FULL;
      end
    end else begin
      if (rd_req) begin
        rd_go   = 1'b1;
        state_d = SLOT_EMPTY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SLOT_EMPTY;
    else     state_q <= state_d;
  end

  assign is_full = (state_q == SLOT_FULL);
  assign blocked = (rd_req && (state_q == SLOT_EMPTY)) ||
                   (wr_req && (state_q == SLOT_FULL));

  // R2 / R4: a granted operation flips the state at the next edge
  a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !is_full) |=> is_full);
  a_r4_read_drains: assert property (@(posedge clk) disable iff (rst)
    (rd_req && is_full) |=> !is_full);

endmodule

// File: rtl/sync_slot_store.sv
module sync_slot_store #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= din;
  end

  assign dout = word_q;

  // R10: the stored word only moves on a completing write
  a_r10_hold_unless_load: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_q));

endmodule

// File: rtl/sync_slot_pulse.sv
module sync_slot_pulse
  import sync_slot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SIDES-1:0] go,
  output logic [NUM_SIDES-1:0] done
);

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic done_q;
    always_ff @(posedge clk) begin
      if (rst) done_q <= 1'b0;
      else     done_q <= go[s];
    end
    assign done[s] = done_q;
  end

  // R9: at most one completion per cycle
  a_r9_one_done: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));

endmodule

// File: rtl/sync_slot_reg.sv
module sync_slot_reg
  import sync_slot_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_req,
  output logic              wr_done,
  input  logic              rd_req,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              blocked
);

  logic                 wr_go;
  logic                 rd_go;
  logic [NUM_SIDES-1:0] go_vec;
  logic [NUM_SIDES-1:0] done_vec;

  sync_slot_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .is_full (full),
    .blocked (blocked)
  );

  sync_slot_store #(.DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .load (wr_go),
    .din  (wr_data),
    .dout (rd_data)
  );

  always_comb begin
    go_vec          = '0;
    go_vec[SIDE_WR] = wr_go;
    go_vec[SIDE_RD] = rd_go;
  end

  sync_slot_pulse u_pulse (
    .clk  (clk),
    .rst  (rst),
    .go   (go_vec),
    .done (done_vec)
  );

  assign wr_done = done_vec[SIDE_WR];
  assign rd_done = done_vec[SIDE_RD];

  // R3: a write against a full slot gives no completion
  a_r3_full_write_stalls: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full) |=> !wr_done);
  // R5: a read against an empty slot gives no completion
  a_r5_empty_read_stalls: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !full) |=> !rd_done);
  // R2: write completion follows an accepted write
  a_r2_write_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !full) |=> wr_done);
  // R4: read completion follows an accepted read
  a_r4_read_pulse: assert property (@(posedge clk) disable iff (rst)
    (rd_req && full) |=> rd_done);

endmodule

// File: tb/sync_slot_reg_tb.sv
module sync_slot_reg_tb;

  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          wr_req = 1'b0;
  logic          rd_req = 1'b0;
  logic          wr_done, rd_done, full, blocked;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sync_slot_reg #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_req(wr_req),
    .wr_done(wr_done), .rd_req(rd_req), .rd_done(rd_done),
    .rd_data(rd_data), .full(full), .blocked(blocked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(full == 1'b0, "R1 full in reset", full, 0);
    chk(wr_done == 1'b0 && rd_done == 1'b0, "R1 dones in reset", {wr_done, rd_done}, 0);
    rst = 1'b0;
    step();
    chk(full == 1'b0, "R1 full after reset", full, 0);
    chk(rd_data == '0, "R1 data after reset", rd_data, 0);
    chk(wr_done == 1'b0 && rd_done == 1'b0, "R1 dones after reset", {wr_done, rd_done}, 0);
    chk(blocked == 1'b0, "R11 idle not blocked", blocked, 0);
  endtask

  task automatic t_read_empty();
    rd_req = 1'b1;
    #1;
    chk(blocked == 1'b1, "R11 read on empty blocked", blocked, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(rd_done == 1'b0, "R5 read on empty stalls", rd_done, 0);
      chk(blocked == 1'b1, "R11 still blocked", blocked, 1);
    end
    rd_req = 1'b0;
    #1;
    chk(blocked == 1'b0, "R11 released", blocked, 0);
  endtask

  task automatic do_write(input logic [DW-1:0] d, input string tag);
    wr_data = d;
    wr_req  = 1'b1;
    step();
    chk(wr_done == 1'b1, {tag, " wr_done"}, wr_done, 1);
    chk(full == 1'b1, {tag, " full"}, full, 1);
    chk(rd_data == d, {tag, " stored"}, rd_data, d);
    wr_req = 1'b0;
  endtask

  task automatic do_read(input logic [DW-1:0] exp, input string tag);
    rd_req = 1'b1;
    step();
    chk(rd_done == 1'b1, {tag, " rd_done"}, rd_done, 1);
    chk(rd_data == exp, {tag, " data"}, rd_data, exp);
    chk(full == 1'b0, {tag, " empty"}, full, 0);
    rd_req = 1'b0;
  endtask

  task automatic t_write_then_stall();
    do_write(8'hA5, "R2 write empty");
    step();
    chk(wr_done == 1'b0, "R9 wr_done single cycle", wr_done, 0);
    wr_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      wr_data = 8'h10 + 8'(i);
      #1;
      chk(blocked == 1'b1, "R11 write on full blocked", blocked, 1);
      step();
      chk(wr_done == 1'b0, "R3 write on full stalls", wr_done, 0);
      chk(rd_data == 8'hA5, "R10 stalled data not sampled", rd_data, 8'hA5);
    end
    wr_req = 1'b0;
  endtask

  task automatic t_read_twice();
    do_read(8'hA5, "R4 read full");
    step();
    chk(rd_done == 1'b0, "R9 rd_done single cycle", rd_done, 0);
    rd_req = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk(rd_done == 1'b0, "R6 second read blocks", rd_done, 0);
    end
    rd_req = 1'b0;
    step();
  endtask

  task automatic t_both_full();
    do_write(8'h3C, "R7 setup");
    wr_data = 8'hC3;
    wr_req  = 1'b1;
    rd_req  = 1'b1;
    step();
    chk(rd_done == 1'b1 && wr_done == 1'b0, "R7 read wins on full", {rd_done, wr_done}, 2);
    chk(rd_data == 8'h3C, "R7 read data", rd_data, 8'h3C);
    rd_req = 1'b0;
    step();
    chk(wr_done == 1'b1 && rd_done == 1'b0, "R7 write follows", {wr_done, rd_done}, 2);
    chk(rd_data == 8'hC3, "R7 new word stored", rd_data, 8'hC3);
    wr_req = 1'b0;
    do_read(8'hC3, "R7 drain");
  endtask

  task automatic t_both_empty();
    wr_data = 8'h5A;
    wr_req  = 1'b1;
    rd_req  = 1'b1;
    step();
    chk(wr_done == 1'b1 && rd_done == 1'b0, "R8 write wins on empty", {wr_done, rd_done}, 2);
    wr_req  = 1'b0;
    wr_data = 8'hFF;
    step();
    chk(rd_done == 1'b1 && wr_done == 1'b0, "R8 read follows", {rd_done, wr_done}, 2);
    chk(rd_data == 8'h5A, "R8 read returns new word", rd_data, 8'h5A);
    chk(full == 1'b0, "R8 empty after", full, 0);
    rd_req = 1'b0;
  endtask

  task automatic t_stream();
    for (int i = 0; i < 5; i++) begin
      do_write(8'(8'h40 + 8'(i * 7)), "R12 stream write");
      do_read(8'(8'h40 + 8'(i * 7)), "R12 stream order");
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_read_empty();
    t_write_then_stall();
    t_read_twice();
    t_both_full();
    t_both_empty();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule